// File: doc/BRIEF.md
# Prescaled Interval Timer with Event Capture

This block is a 16-bit general-purpose interval timer that is driven from a small register port. Software sets a reload value and picks a count direction and one of four prescale ratios. It then sets the enable bit. While the timer runs, the counter steps once each time the prescaler reaches its terminal count. When a down-count would reach zero, or an up-count would reach full scale, the counter reloads from the reload register, sets a sticky timeout flag and raises the timeout interrupt pin.

A 32-line event vector feeds the capture unit. A 5-bit select field in the control register picks one line. A rising edge on that line copies the live count into a capture register and sets a capture-pending flag. While the flag is set, the captured value is locked and later edges are ignored. Software releases the lock by writing a one to the matching bit of the clear register.

The register port is a plain single-cycle write strobe and a combinational read mux. It has no back-pressure: every write takes effect at the next clock edge, and read data depends only on the read address and the current state.

Top module: `evt_timer`

## Requirements
- R1: After reset, every readable register (reload, count, control, capture, status) reads zero, and both interrupt pins are low.
- R2: A control write that sets enable (control bit 4) while the timer is stopped loads the counter from the reload register and restarts the prescaler. While enable is 0 the count holds its value.
- R3: Control bits [3:2] select the prescale ratio (0: 1, 1: 4, 2: 16, 3: 256). The counter steps exactly once per ratio clock cycles.
- R4: With control bit 0 = 0 (down), the timeout flag is set every reload×ratio cycles. On the step where the count would reach zero, the counter reloads instead, and the count decreases by one on every other step.
- R5: With control bit 0 = 1 (up), the timeout flag is set every (0xFFFF − reload)×ratio cycles. On the step where the count would reach 0xFFFF, the counter reloads.
- R6: Status bit 0 is the sticky timeout flag and is mirrored on `irq_timeout`. Writing 1 to clear-register bit 0 clears it.
- R7: Control bits [12:8] select one event line. A rising edge on that line while no capture is pending copies the current count into the capture register and sets status bit 1, which is mirrored on `irq_capture`.
- R8: While status bit 1 is set, the capture register keeps its value and further edges are ignored. Writing 1 to clear-register bit 1 clears the flag.
- R9: Only a 0-to-1 transition of the selected line captures. A line held high, or edges on unselected lines, cause no capture.
- R10: Register map: address 0 is reload (read/write), 1 is the live count (read), 2 is control (read/write; only bits 0, 2, 3, 4 and 8–12 are stored, the rest read 0), 3 is capture (read), 4 is status (read), and 5 is clear (write, reads 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 16 | Register read data (combinational) |
| evt_in | input | 32 | Capture event lines |
| irq_timeout | output | 1 | Timeout flag (status bit 0) |
| irq_capture | output | 1 | Capture-pending flag (status bit 1) |

## Verification
On every cycle, the assertions check the following:
- a stopped counter holds its value;
- a down step below the reload point decreases the count by one;
- two prescaler ticks at ratios above one are never adjacent;
- a capture copies the count one edge later;
- a pending capture stays frozen until it is cleared;
- the timeout flag stays high until it is cleared.

The exact period for each ratio and direction, the lock-out against a held-high or unselected line, and the register readback masking can only be shown by the bench. It measures the cycles between interrupt edges and drives event sequences, and it checks each cycle against its behavioural model.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;
  localparam int CNT_W   = 16;
  localparam int ADDR_W  = 3;
  localparam int PRE_W   = 8;

  localparam logic [ADDR_W-1:0] A_RELOAD  = 3'd0;
  localparam logic [ADDR_W-1:0] A_COUNT   = 3'd1;
  localparam logic [ADDR_W-1:0] A_CTRL    = 3'd2;
  localparam logic [ADDR_W-1:0] A_CAPTURE = 3'd3;
  localparam logic [ADDR_W-1:0] A_STATUS  = 3'd4;
  localparam logic [ADDR_W-1:0] A_CLEAR   = 3'd5;

  localparam int B_UP     = 0;
  localparam int B_PSEL_L = 2;
  localparam int B_EN     = 4;
  localparam int B_ESEL_L = 8;

  localparam logic [CNT_W-1:0] CTRL_MASK = 16'h1F1D;

  function automatic logic [PRE_W-1:0] pre_last(input logic [1:0] sel);
    case (sel)
      2'd0:    pre_last = 8'd0;
      2'd1:    pre_last = 8'd3;
      2'd2:    pre_last = 8'd15;
      default: pre_last = 8'd255;
    endcase
  endfunction
endpackage

// File: rtl/evt_timer_prescaler.sv
module evt_timer_prescaler
  import evt_timer_pkg::*;
#(
  parameter int PW = PRE_W
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       restart,
  input  logic [1:0] sel,
  output logic       tick
);
  logic [PW-1:0] pcnt;
  logic [PW-1:0] last;

  assign last = pre_last(sel);
  assign tick = run && !restart && (pcnt >= last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pcnt <= '0;
    else if (restart) pcnt <= '0;
    else if (run)     pcnt <= tick ? '0 : pcnt + 1'b1;
  end

  // R3: at ratios above one, ticks are separated by idle cycles
  p_tick_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && sel != 2'd0) |=> (!tick || sel == 2'd0));
endmodule

// File: rtl/evt_timer_counter.sv
module evt_timer_counter
  import evt_timer_pkg::*;
#(
  parameter int W = CNT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         tick,
  input  logic         start,
  input  logic         up,
  input  logic [W-1:0] reload,
  output logic [W-1:0] cnt,
  output logic         expire
);
  localparam logic [W-1:0] FULL = {W{1'b1}};
  localparam logic [W-1:0] NEAR = FULL - 1'b1;
  localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};

  logic hit;
  logic step;

  assign hit    = up ? (cnt >= NEAR) : (cnt <= ONE);
  assign step   = run && tick && !start;
  assign expire = step && hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (start)  cnt <= reload;
    else if (step) begin
      if (hit)       cnt <= reload;
      else if (up)   cnt <= cnt + 1'b1;
      else           cnt <= cnt - 1'b1;
    end
  end

  // R2: a stopped counter keeps its value
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !start) |=> $stable(cnt));
  // R4: ordinary down step
  p_down_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !up && cnt > ONE) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/evt_timer_capture.sv
module evt_timer_capture
  import evt_timer_pkg::*;
#(
  parameter int W     = CNT_W,
  parameter int N_EVT = 32,
  localparam int SW   = $clog2(N_EVT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_EVT-1:0] evt,
  input  logic [SW-1:0]    sel,
  input  logic [W-1:0]     count,
  input  logic             clr,
  output logic [W-1:0]     cap_q,
  output logic             pend
);
  logic [N_EVT-1:0] evt_d;
  logic [N_EVT-1:0] rise;
  logic             hit;

  genvar gi;
  generate
    for (gi = 0; gi < N_EVT; gi++) begin : g_edge
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) evt_d[gi] <= 1'b0;
        else        evt_d[gi] <= evt[gi];
      end
      assign rise[gi] = evt[gi] & ~evt_d[gi];
    end
  endgenerate

  assign hit = rise[sel];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q <= '0;
      pend  <= 1'b0;
    end else if (hit && !pend) begin
      cap_q <= count;
      pend  <= 1'b1;
    end else if (clr) begin
      pend  <= 1'b0;
    end
  end

  // R7: a capture takes the count present at the edge
  p_cap_take_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !pend) |=> (pend && cap_q == $past(count)));
  // R8: pending capture stays frozen until cleared
  p_cap_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !clr) |=> (pend && $stable(cap_q)));
endmodule

// File: rtl/evt_timer.sv
module evt_timer
  import evt_timer_pkg::*;
#(
  parameter int N_EVT = 32,
  localparam int SW   = $clog2(N_EVT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [CNT_W-1:0]  rd_data,
  input  logic [N_EVT-1:0]  evt_in,
  output logic              irq_timeout,
  output logic              irq_capture
);
  logic [CNT_W-1:0] reload_q;
  logic [CNT_W-1:0] ctrl_q;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cap_q;
  logic             to_q;
  logic             pend;
  logic             run;
  logic             start;
  logic             tick;
  logic             expire;
  logic             clr_to;
  logic             clr_cap;
  logic             wr_ctrl;

  assign run     = ctrl_q[B_EN];
  assign wr_ctrl = wr_en && (wr_addr == A_CTRL);
  assign start   = wr_ctrl && wr_data[B_EN] && !run;
  assign clr_to  = wr_en && (wr_addr == A_CLEAR) && wr_data[0];
  assign clr_cap = wr_en && (wr_addr == A_CLEAR) && wr_data[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_q <= '0;
      ctrl_q   <= '0;
    end else if (wr_en) begin
      if (wr_addr == A_RELOAD) reload_q <= wr_data;
      if (wr_ctrl)             ctrl_q   <= wr_data & CTRL_MASK;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      to_q <= 1'b0;
    else if (expire) to_q <= 1'b1;
    else if (clr_to) to_q <= 1'b0;
  end

  evt_timer_prescaler u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .restart (start),
    .sel     (ctrl_q[B_PSEL_L +: 2]),
    .tick    (tick)
  );

  evt_timer_counter #(.W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .tick    (tick),
    .start   (start),
    .up      (ctrl_q[B_UP]),
    .reload  (reload_q),
    .cnt     (cnt),
    .expire  (expire)
  );

  evt_timer_capture #(.W(CNT_W), .N_EVT(N_EVT)) u_cap (
    .clk     (clk),
    .rst_n   (rst_n),
    .evt     (evt_in),
    .sel     (ctrl_q[B_ESEL_L +: SW]),
    .count   (cnt),
    .clr     (clr_cap),
    .cap_q   (cap_q),
    .pend    (pend)
  );

  always_comb begin
    case (rd_addr)
      A_RELOAD:  rd_data = reload_q;
      A_COUNT:   rd_data = cnt;
      A_CTRL:    rd_data = ctrl_q;
      A_CAPTURE: rd_data = cap_q;
      A_STATUS:  rd_data = {{(CNT_W-2){1'b0}}, pend, to_q};
      default:   rd_data = '0;
    endcase
  end

  assign irq_timeout = to_q;
  assign irq_capture = pend;

  // R6: the timeout flag is sticky until a clear write
  p_to_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_timeout && !clr_to) |=> irq_timeout);
  // R6: the flag rises only on a reload event
  p_to_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_timeout && !expire) |=> !irq_timeout);
endmodule

// File: tb/evt_timer_tb.sv
module evt_timer_tb;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic [31:0] evt_in = '0;
  logic        irq_timeout;
  logic        irq_capture;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;
  int cyc = 0;
  int rise_cnt = 0;
  int rise_cyc = 0;
  logic prev_to = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  evt_timer u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .evt_in(evt_in), .irq_timeout(irq_timeout), .irq_capture(irq_capture)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // behavioural reference model
  logic [15:0] m_load, m_ctrl, m_cnt, m_cap;
  logic        m_to, m_cp;
  logic [31:0] m_prev;
  int          m_pc;

  function automatic int ratio(input logic [1:0] s);
    case (s)
      2'd0: return 1;
      2'd1: return 4;
      2'd2: return 16;
      default: return 256;
    endcase
  endfunction

  function automatic logic [15:0] m_read(input logic [2:0] a);
    case (a)
      3'd0: return m_load;
      3'd1: return m_cnt;
      3'd2: return m_ctrl;
      3'd3: return m_cap;
      3'd4: return {14'd0, m_cp, m_to};
      default: return 16'd0;
    endcase
  endfunction

  always @(posedge clk) begin
    logic [15:0] n_load, n_ctrl, n_cnt, n_cap;
    logic n_to, n_cp, st, c0, c1, exp_hit, tk;
    int n_pc;
    int sel;
    cyc++;
    if (!rst_n) begin
      m_load = 0; m_ctrl = 0; m_cnt = 0; m_cap = 0;
      m_to = 0; m_cp = 0; m_prev = 0; m_pc = 0;
    end else begin
      n_load = m_load; n_ctrl = m_ctrl; n_cnt = m_cnt; n_cap = m_cap;
      n_to = m_to; n_cp = m_cp; n_pc = m_pc;
      st = 0; c0 = 0; c1 = 0; exp_hit = 0;
      if (wr_en) begin
        if (wr_addr == 3'd0) n_load = wr_data;
        if (wr_addr == 3'd2) begin
          n_ctrl = wr_data & 16'h1F1D;
          st = wr_data[4] && !m_ctrl[4];
        end
        if (wr_addr == 3'd5) begin c0 = wr_data[0]; c1 = wr_data[1]; end
      end
      if (st) begin
        n_cnt = m_load; n_pc = 0;
      end else if (m_ctrl[4]) begin
        tk = (m_pc >= ratio(m_ctrl[3:2]) - 1);
        n_pc = tk ? 0 : m_pc + 1;
        if (tk) begin
          exp_hit = m_ctrl[0] ? (m_cnt >= 16'hFFFE) : (m_cnt <= 16'd1);
          if (exp_hit)        n_cnt = m_load;
          else if (m_ctrl[0]) n_cnt = m_cnt + 16'd1;
          else                n_cnt = m_cnt - 16'd1;
        end
      end
      if (c0) n_to = 0;
      if (exp_hit) n_to = 1;
      if (c1) n_cp = 0;
      sel = int'(m_ctrl[12:8]);
      if (evt_in[sel] && !m_prev[sel] && !m_cp) begin
        n_cap = m_cnt; n_cp = 1;
      end
      m_prev = evt_in;
      m_load = n_load; m_ctrl = n_ctrl; m_cnt = n_cnt; m_cap = n_cap;
      m_to = n_to; m_cp = n_cp; m_pc = n_pc;
    end
    #(CLK_P/4);
    if (rst_n && !done) begin
      check(irq_timeout == m_to, "R6 model timeout pin", irq_timeout, m_to);
      check(irq_capture == m_cp, "R7 model capture pin", irq_capture, m_cp);
      check(rd_data == m_read(rd_addr), "R10 model read", rd_data, m_read(rd_addr));
    end
    if (irq_timeout && !prev_to) begin
      rise_cnt++;
      rise_cyc = cyc;
    end
    prev_to = irq_timeout;
  end

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] v);
    @(negedge clk);
    rd_addr = a;
    #1 v = rd_data;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rd_addr = (rd_addr == 3'd4) ? 3'd0 : rd_addr + 3'd1;
    end
  endtask

  task automatic wait_rise(output int c);
    int s;
    s = rise_cnt;
    while (rise_cnt == s) @(negedge clk);
    c = rise_cyc;
  endtask

  task automatic measure(input logic [15:0] ld, input logic [15:0] ctl,
                         input int exp, input string tag);
    int a, b;
    wr(3'd2, 16'h0000);
    wr(3'd0, ld);
    wr(3'd2, ctl);
    wr(3'd5, 16'h0001);
    wait_rise(a);
    wr(3'd5, 16'h0001);
    wait_rise(b);
    check((b - a) == exp, tag, b - a, exp);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
    finish_run();
  end

  initial begin
    logic [15:0] v, v2, c;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1: reset values
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), v);
      check(v == 16'h0000, "R1 reset register", v, 0);
    end
    check(!irq_timeout && !irq_capture, "R1 reset pins", {irq_timeout, irq_capture}, 0);

    // R10: readback and control masking
    wr(3'd0, 16'hABCD);
    rd(3'd0, v); check(v == 16'hABCD, "R10 reload readback", v, 16'hABCD);
    wr(3'd2, 16'hE0E2);
    rd(3'd2, v); check(v == 16'h0000, "R10 control mask", v, 0);
    rd(3'd5, v); check(v == 16'h0000, "R10 clear reads zero", v, 0);

    // R4/R3/R5 periods
    measure(16'd4,      16'h0010, 4,   "R4 down period ratio1");
    measure(16'd3,      16'h0014, 12,  "R3 down period ratio4");
    measure(16'hFFF0,   16'h0011, 15,  "R5 up period ratio1");
    measure(16'hFFF0,   16'h0019, 240, "R3 up period ratio16");
    measure(16'd2,      16'h001C, 512, "R3 down period ratio256");

    // R6: clear of timeout
    wr(3'd2, 16'h0000);
    wr(3'd5, 16'h0003);
    check(irq_timeout == 1'b0, "R6 timeout cleared", irq_timeout, 0);

    // R2 / R7: capture of a frozen count
    wr(3'd0, 16'd100);
    wr(3'd2, 16'h0710);
    idle(7);
    wr(3'd2, 16'h0700);
    rd(3'd1, v);
    check(v != 16'd100 && v < 16'd100, "R2 counter ran from reload", v, 100);
    idle(5);
    rd(3'd1, v2);
    check(v2 == v, "R2 stopped count holds", v2, v);
    @(negedge clk); evt_in[7] = 1'b1;
    rd(3'd3, c);
    check(c == v, "R7 captured count", c, v);
    check(irq_capture == 1'b1, "R7 capture pin", irq_capture, 1);
    rd(3'd4, c);
    check(c == 16'h0002, "R7 status pending", c, 2);

    // R8: lock-out while pending
    evt_in[7] = 1'b0;
    wr(3'd2, 16'h0710);
    idle(6);
    evt_in[7] = 1'b1;
    idle(3);
    rd(3'd3, c);
    check(c == v, "R8 capture frozen", c, v);
    wr(3'd5, 16'h0002);
    check(irq_capture == 1'b0, "R8 capture cleared", irq_capture, 0);

    // R9: held high and unselected lines
    idle(5);
    check(irq_capture == 1'b0, "R9 held line no capture", irq_capture, 0);
    evt_in[3] = 1'b1;
    idle(3);
    check(irq_capture == 1'b0, "R9 unselected line ignored", irq_capture, 0);
    rd(3'd3, c);
    check(c == v, "R9 capture unchanged", c, v);

    // R7: new capture after release, then another select value
    wr(3'd2, 16'h0700);
    rd(3'd1, v);
    evt_in[7] = 1'b0;
    @(negedge clk); evt_in[7] = 1'b1;
    rd(3'd3, c);
    check(c == v, "R7 recapture after clear", c, v);
    wr(3'd5, 16'h0002);
    wr(3'd2, 16'h0300);
    evt_in[3] = 1'b0;
    @(negedge clk); evt_in[3] = 1'b1;
    idle(2);
    check(irq_capture == 1'b1, "R7 select line 3", irq_capture, 1);

    idle(4);
    finish_run();
  end
endmodule